// File: doc/BRIEF.md
# Vectored Interrupt Unit with Context Shadowing

This unit holds the interrupt logic of a small 8-bit processor core. Four event sources (comparator, high-time counter underflow, low-time counter underflow, low-voltage detect) each set a latched flag. A per-source mask and a global enable gate the flags into one request to the core. Software reads and writes the flags and the mask through register strobes. The core's enable-interrupt, disable-interrupt and return-from-interrupt decodes drive the global enable.

At each instruction boundary the core pulses an instruction-complete strobe. If a request is pending at that moment, the unit takes the interrupt. In the next cycle it presents a fixed vector address for the winning source and raises a take strobe. At the same clock edge it copies the live accumulator, status and file-select registers into a single shadow set. There is only one shadow level, so a nested interrupt overwrites it. On return-from-interrupt the unit raises a restore strobe, and the core loads the shadow values back into its registers.

Top module: `vec_irq_unit`

## Requirements
- R1: After reset, all flags, the mask, the global enable, the request, the take and restore strobes and the shadow values are zero.
- R2: A pulse on a source event bit sets the matching flag, and the flag is visible on `flag_o` in the next cycle.
- R3: A flag write clears each flag whose write-data bit is 0 and leaves unchanged each flag whose write-data bit is 1. A source event in the same cycle keeps its flag set. Flags change only through events and writes.
- R4: A mask write loads `mask_o`. `irq_o` is high exactly when the global enable is on and at least one flag has its mask bit set.
- R5: `eni_i` sets the global enable and `disi_i` clears it. When both are high, `disi_i` wins.
- R6: When `instr_done_i` and `irq_o` are both high, `take_o` is high for one cycle in the next cycle and the global enable is then off. Without `instr_done_i`, or without a request, nothing is taken.
- R7: The vector addresses are: bit 0, comparator, 0x00F; bit 1, high-time, 0x012; bit 2, low-time, 0x015; bit 3, low-voltage, 0x021.
- R8: When several unmasked flags are pending, the lowest bit index wins (comparator, then high-time, then low-time, then low-voltage).
- R9: On a take, `acc_rst_o`, `status_rst_o` and `fsr_rst_o` capture `acc_i`, `status_i` and `fsr_i` from the strobe cycle. They hold those values until the next take.
- R10: A second take while the shadow is occupied overwrites the shadow with the newer values.
- R11: `reti_i` produces a one-cycle `restore_o` in the next cycle carrying the shadow values, and turns the global enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_evt_i | input | 4 | Source event pulses, bit per source |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 4 | Flag write data (0 clears) |
| flag_o | output | 4 | Flag register read value |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 4 | Mask write data |
| mask_o | output | 4 | Mask register read value |
| eni_i | input | 1 | Enable-interrupt decode |
| disi_i | input | 1 | Disable-interrupt decode |
| reti_i | input | 1 | Return-from-interrupt decode |
| instr_done_i | input | 1 | Instruction boundary strobe |
| acc_i | input | 8 | Live accumulator |
| status_i | input | 8 | Live status register |
| fsr_i | input | 8 | Live file-select register |
| irq_o | output | 1 | Interrupt request to core |
| take_o | output | 1 | Interrupt taken, save done |
| vec_addr_o | output | 10 | Vector address of taken interrupt |
| gie_o | output | 1 | Global enable state |
| restore_o | output | 1 | Restore strobe after return |
| acc_rst_o | output | 8 | Shadow accumulator |
| status_rst_o | output | 8 | Shadow status |
| fsr_rst_o | output | 8 | Shadow file-select |

## Verification
The bench targets the same-cycle collision of a flag clear and a source event. A design that let the clear win would lose an interrupt. It writes ones to the flags, which a design treating the write as a plain load would also pass. So the bench checks that a flag write of 1 cannot set a flag that is clear, and that a flag write of 0 cannot clear a flag that is set. It also checks that `eni_i` and `disi_i` together leave the enable off, which a design giving `eni_i` priority would get wrong. It checks that multiple pending sources resolve to the lowest index, which a reversed priority encoder would get wrong, and that a pending request without the boundary strobe is not taken. A nested take must overwrite the shadow. A design that kept the first save would restore stale accumulator values.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned VEC_W = 10;

  typedef enum logic [IDX_W-1:0] {
    SRC_CMP = 2'd0,
    SRC_HI  = 2'd1,
    SRC_LO  = 2'd2,
    SRC_LVD = 2'd3
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (src_e'(idx))
      SRC_CMP: vec_of = VEC_W'(12'h00F);
      SRC_HI:  vec_of = VEC_W'(12'h012);
      SRC_LO:  vec_of = VEC_W'(12'h015);
      default: vec_of = VEC_W'(12'h021);
    endcase
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic clr;
    assign clr = wr_i & ~wdata_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[g] <= 1'b0;
      else if (evt_i[g])  flag_o[g] <= 1'b1;  // event beats clear
      else if (clr)       flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              reti_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] fsr_i,
  output logic              restore_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] fsr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o    <= '0;
      status_o <= '0;
      fsr_o    <= '0;
    end else if (save_i) begin
      acc_o    <= acc_i;
      status_o <= status_i;
      fsr_o    <= fsr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restore_o <= 1'b0;
    else         restore_o <= reti_i;
  end
endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
  import vec_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_evt_i,
  input  logic              flag_wr_i,
  input  logic [NSRC-1:0]   flag_wdata_i,
  output logic [NSRC-1:0]   flag_o,
  input  logic              mask_wr_i,
  input  logic [NSRC-1:0]   mask_wdata_i,
  output logic [NSRC-1:0]   mask_o,
  input  logic              eni_i,
  input  logic              disi_i,
  input  logic              reti_i,
  input  logic              instr_done_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] fsr_i,
  output logic              irq_o,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_addr_o,
  output logic              gie_o,
  output logic              restore_o,
  output logic [DATA_W-1:0] acc_rst_o,
  output logic [DATA_W-1:0] status_rst_o,
  output logic [DATA_W-1:0] fsr_rst_o
);
  logic [NSRC-1:0]  live_req;
  logic             any_req;
  logic [IDX_W-1:0] win_idx;
  logic             take_now;

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (src_evt_i),
    .wr_i    (flag_wr_i),
    .wdata_i (flag_wdata_i),
    .flag_o  (flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_wr_i) mask_o <= mask_wdata_i;
  end

  assign live_req = flag_o & mask_o;

  irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .req_i (live_req),
    .any_o (any_req),
    .idx_o (win_idx)
  );

  assign irq_o    = gie_o & any_req;
  assign take_now = instr_done_i & irq_o;

  // take beats disable beats enable/return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gie_o <= 1'b0;
    else if (take_now)         gie_o <= 1'b0;
    else if (disi_i)           gie_o <= 1'b0;
    else if (eni_i || reti_i)  gie_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      vec_addr_o <= '0;
    end else begin
      take_o <= take_now;
      if (take_now) vec_addr_o <= vec_of(win_idx);
    end
  end

  irq_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .save_i    (take_now),
    .reti_i    (reti_i),
    .acc_i     (acc_i),
    .status_i  (status_i),
    .fsr_i     (fsr_i),
    .restore_o (restore_o),
    .acc_o     (acc_rst_o),
    .status_o  (status_rst_o),
    .fsr_o     (fsr_rst_o)
  );
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk
  import vec_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   src_evt_i,
  input logic              flag_wr_i,
  input logic [NSRC-1:0]   flag_wdata_i,
  input logic [NSRC-1:0]   flag_o,
  input logic              mask_wr_i,
  input logic [NSRC-1:0]   mask_wdata_i,
  input logic [NSRC-1:0]   mask_o,
  input logic              eni_i,
  input logic              disi_i,
  input logic              reti_i,
  input logic              instr_done_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] fsr_i,
  input logic              irq_o,
  input logic              take_o,
  input logic [VEC_W-1:0]  vec_addr_o,
  input logic              gie_o,
  input logic              restore_o,
  input logic [DATA_W-1:0] acc_rst_o,
  input logic [DATA_W-1:0] status_rst_o,
  input logic [DATA_W-1:0] fsr_rst_o
);
  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_evt_i) |=> ((flag_o & $past(src_evt_i)) == $past(src_evt_i)));

  a_r3_no_drop_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  a_r3_write_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i |=> ((flag_o & $past(flag_o & flag_wdata_i)) == $past(flag_o & flag_wdata_i)));

  a_r6_take_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_done_i && irq_o) |=> (take_o && !gie_o));

  a_r6_no_spurious_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_done_i && irq_o) |=> !take_o);

  a_r7_vec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_addr_o == 10'h00F || vec_addr_o == 10'h012 ||
                vec_addr_o == 10'h015 || vec_addr_o == 10'h021));

  a_r9_shadow_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable({acc_rst_o, status_rst_o, fsr_rst_o}));

  a_r11_restore_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> restore_o);
endmodule

bind vec_irq_unit vec_irq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_vec_irq_unit.sv
module test_vec_irq_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] src_evt_i = '0;
  logic       flag_wr_i = 1'b0;
  logic [3:0] flag_wdata_i = '0;
  logic [3:0] flag_o;
  logic       mask_wr_i = 1'b0;
  logic [3:0] mask_wdata_i = '0;
  logic [3:0] mask_o;
  logic       eni_i = 1'b0, disi_i = 1'b0, reti_i = 1'b0, instr_done_i = 1'b0;
  logic [7:0] acc_i = '0, status_i = '0, fsr_i = '0;
  logic       irq_o, take_o, gie_o, restore_o;
  logic [9:0] vec_addr_o;
  logic [7:0] acc_rst_o, status_rst_o, fsr_rst_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  vec_irq_unit i_vec_irq_unit (.*);

  typedef struct packed {
    logic [3:0] evt;
    logic [3:0] mask;
    logic       tk;
    logic [9:0] vec;
  } row_t;

  localparam int NROW = 10;
  localparam row_t TBL [NROW] = '{
    '{4'b0001, 4'b1111, 1'b1, 10'h00F},
    '{4'b0010, 4'b1111, 1'b1, 10'h012},
    '{4'b0100, 4'b1111, 1'b1, 10'h015},
    '{4'b1000, 4'b1111, 1'b1, 10'h021},
    '{4'b1111, 4'b1111, 1'b1, 10'h00F},
    '{4'b1110, 4'b1111, 1'b1, 10'h012},
    '{4'b1100, 4'b1111, 1'b1, 10'h015},
    '{4'b1111, 4'b1000, 1'b1, 10'h021},
    '{4'b1011, 4'b1110, 1'b1, 10'h012},
    '{4'b0101, 4'b1010, 1'b0, 10'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk_i);
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    src_evt_i = e; tick; src_evt_i = '0;
  endtask

  task automatic wr_flags(input logic [3:0] d);
    flag_wr_i = 1'b1; flag_wdata_i = d; tick; flag_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick; tick;
    // R1 reset state
    chk("R1 flags", flag_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 gie", gie_o, 0);
    chk("R1 irq/take/restore", {irq_o, take_o, restore_o}, 0);
    chk("R1 shadow", {acc_rst_o, status_rst_o, fsr_rst_o}, 0);
    rst_ni = 1'b1;
    tick;

    // table walk: R4 R6 R7 R8 R9 R11
    for (int i = 0; i < NROW; i++) begin
      mask_wr_i = 1'b1; mask_wdata_i = TBL[i].mask;
      flag_wr_i = 1'b1; flag_wdata_i = '0; eni_i = 1'b1;
      tick;
      mask_wr_i = 1'b0; flag_wr_i = 1'b0; eni_i = 1'b0;
      chk("R4 mask readback", mask_o, TBL[i].mask);
      pulse_evt(TBL[i].evt);
      chk("R2 flag set", flag_o, TBL[i].evt);
      chk("R4 irq level", irq_o, TBL[i].tk);
      acc_i = 8'h30 + 8'(i); status_i = 8'hC0 + 8'(i); fsr_i = 8'h70 + 8'(i);
      instr_done_i = 1'b1; tick; instr_done_i = 1'b0;
      chk("R6 take", take_o, TBL[i].tk);
      if (TBL[i].tk) begin
        chk("R7/R8 vector", vec_addr_o, TBL[i].vec);
        chk("R6 gie off", gie_o, 0);
        chk("R9 shadow", {acc_rst_o, status_rst_o, fsr_rst_o},
            {8'h30 + 8'(i), 8'hC0 + 8'(i), 8'h70 + 8'(i)});
        reti_i = 1'b1; tick; reti_i = 1'b0;
        chk("R11 restore", restore_o, 1);
        chk("R11 gie on", gie_o, 1);
        chk("R11 values", acc_rst_o, 8'h30 + 8'(i));
        tick;
        chk("R11 one-shot", restore_o, 0);
      end
    end

    // R3 write semantics
    wr_flags(4'b0000);
    pulse_evt(4'b0101);
    wr_flags(4'b1111);
    chk("R3 write ones keeps", flag_o, 4'b0101);
    wr_flags(4'b1010);
    chk("R3 write zero clears / one no set", flag_o, 4'b0000);
    pulse_evt(4'b0010);
    src_evt_i = 4'b0010; flag_wr_i = 1'b1; flag_wdata_i = 4'b0000; tick;
    src_evt_i = '0; flag_wr_i = 1'b0;
    chk("R3 event beats clear", flag_o, 4'b0010);

    // R5 enable/disable
    eni_i = 1'b1; disi_i = 1'b1; tick; eni_i = 1'b0; disi_i = 1'b0;
    chk("R5 disi wins", gie_o, 0);
    eni_i = 1'b1; tick; eni_i = 1'b0;
    chk("R5 eni sets", gie_o, 1);
    disi_i = 1'b1; tick; disi_i = 1'b0;
    chk("R5 disi clears", gie_o, 0);

    // R6 gie off: no take even at boundary
    mask_wr_i = 1'b1; mask_wdata_i = 4'b1111; tick; mask_wr_i = 1'b0;
    instr_done_i = 1'b1; tick; instr_done_i = 1'b0;
    chk("R6 no take gie off", take_o, 0);
    // R6 request but no boundary strobe
    eni_i = 1'b1; tick; eni_i = 1'b0;
    chk("R4 irq high", irq_o, 1);
    tick; tick;
    chk("R6 no take without boundary", take_o, 0);

    // R10 nested overwrite
    acc_i = 8'hAA; status_i = 8'h11; fsr_i = 8'h22;
    instr_done_i = 1'b1; tick; instr_done_i = 1'b0;
    chk("R6 first take", take_o, 1);
    chk("R7 high-time vec", vec_addr_o, 10'h012);
    eni_i = 1'b1; tick; eni_i = 1'b0;
    acc_i = 8'h55; status_i = 8'h66; fsr_i = 8'h77;
    instr_done_i = 1'b1; tick; instr_done_i = 1'b0;
    chk("R10 second take", take_o, 1);
    chk("R10 overwrite", {acc_rst_o, status_rst_o, fsr_rst_o}, {8'h55, 8'h66, 8'h77});
    reti_i = 1'b1; tick; reti_i = 1'b0;
    chk("R10 restore newer", {restore_o, acc_rst_o}, {1'b1, 8'h55});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule